// File: doc/BRIEF.md
# Injected Event Descriptor Validator

This block judges whether a descriptor for an event that is about to be injected is self-consistent. The descriptor has three parts: a 32-bit information word (vector, event kind, error-code flag, reserved bits and an armed bit), a 32-bit error-code word, and an instruction-length value. On a one-cycle check strobe the block samples all three. One cycle later it returns a done pulse, a seven-bit vector with one bit for each rule that was broken, and a single fail flag.

The block only evaluates the descriptor. The caller holds the descriptor and acts on the verdict. If the armed bit of the information word is clear, no event is pending, so every rule is skipped and the verdict is a pass.

Top module: `inj_evt_validator`

## Requirements
- R1: When bit 31 of the information word is 0 at the strobe, the result has a violation vector of 0 and fail low, whatever the other inputs hold.
- R2: The event kind is bits 10:8. The kinds are 0 external interrupt, 2 NMI, 3 hardware exception, 4 software interrupt, 5 privileged software exception and 6 software exception. Kind 1 or kind 7 sets violation bit 0.
- R3: For kind 2, a vector (bits 7:0) other than 2 sets violation bit 1.
- R4: For kind 3, a vector greater than 31 sets violation bit 2.
- R5: Violation bit 3 is set when bit 11 (error-code flag) differs from "kind is 3 and vector is one of 8, 10, 11, 12, 13, 14, 17".
- R6: Any set bit among bits 30:12 of the information word sets violation bit 4.
- R7: When bit 11 is 1, any set bit among bits 31:15 of the error-code word sets violation bit 5. When bit 11 is 0, the error-code word has no effect.
- R8: For kinds 4, 5 and 6, an instruction length below 1 or above 15 sets violation bit 6. For the other kinds the length has no effect.
- R9: The fail output equals the OR of the seven violation bits and is valid in the same cycle as them.
- R10: Reset clears done, fail and the violation vector. Done is high for exactly the cycle after each strobe. Without a strobe, fail and the violation vector keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_valid | input | 1 | Check strobe; inputs are sampled when high |
| evt_info | input | 32 | Event information word |
| evt_errcode | input | 32 | Error code to be delivered with the event |
| evt_ilen | input | ILEN_W (5) | Instruction length for software-originated kinds |
| chk_done | output | 1 | Result pulse, one cycle after each strobe |
| chk_fail | output | 1 | High when any rule was broken |
| chk_viol | output | 7 | One bit per broken rule, bit positions as in R2 to R8 |

## Verification
Every result appears exactly one clock edge after the strobe edge that sampled it. The bench drives the strobe and the descriptor on a falling edge. It reads done, fail and the violation vector on the next falling edge, which is half a cycle after the register updates. It reads the same outputs one cycle later to confirm that done has dropped and the vector is held. Back-to-back strobes are checked edge by edge, so each result must land in its own cycle. The hold tests change the inputs while the strobe is low and then read the registered outputs, so any input that leaks through would show up.

// File: rtl/inj_evt_pkg.sv
package inj_evt_pkg;

   // Information-word layout (fixed by the consumers of this word)
   localparam int INFO_W     = 32;
   localparam int ARMED_BIT  = 31;
   localparam int RSV_MSB    = 30;
   localparam int RSV_LSB    = 12;
   localparam int RSV_W      = RSV_MSB - RSV_LSB + 1;
   localparam int DELIV_BIT  = 11;
   localparam int KIND_MSB   = 10;
   localparam int KIND_LSB   = 8;
   localparam int KIND_W     = KIND_MSB - KIND_LSB + 1;
   localparam int VEC_MSB    = 7;
   localparam int VEC_W      = VEC_MSB + 1;

   // Rule positions in the violation vector
   localparam int RULE_RSV_KIND  = 0;
   localparam int RULE_NMI_VEC   = 1;
   localparam int RULE_HWEXC_VEC = 2;
   localparam int RULE_ERRFLAG   = 3;
   localparam int RULE_RSV_BITS  = 4;
   localparam int RULE_ERR_HI    = 5;
   localparam int RULE_ILEN      = 6;
   localparam int NUM_RULES      = 7;

   typedef logic [NUM_RULES-1:0] viol_t;

   typedef enum logic [KIND_W-1:0] {
      KIND_EXTINT = 3'd0,
      KIND_RSV1   = 3'd1,
      KIND_NMI    = 3'd2,
      KIND_HWEXC  = 3'd3,
      KIND_SWINT  = 3'd4,
      KIND_PRIVSW = 3'd5,
      KIND_SWEXC  = 3'd6,
      KIND_RSV7   = 3'd7
   } evt_kind_e;

   typedef struct packed {
      logic             armed;
      logic [RSV_W-1:0] rsv;
      logic             deliver;
      evt_kind_e        kind;
      logic [VEC_W-1:0] vec;
   } info_fields_t;

endpackage

// File: rtl/inj_evt_fields.sv
module inj_evt_fields
   import inj_evt_pkg::*;
(
   input  logic [INFO_W-1:0] info,
   output info_fields_t      fields
);

   always_comb begin
      fields.armed   = info[ARMED_BIT];
      fields.rsv     = info[RSV_MSB:RSV_LSB];
      fields.deliver = info[DELIV_BIT];
      fields.kind    = evt_kind_e'(info[KIND_MSB:KIND_LSB]);
      fields.vec     = info[VEC_MSB:0];
   end

endmodule

// File: rtl/inj_evt_rules.sv
module inj_evt_rules
   import inj_evt_pkg::*;
#(
   parameter int          ERR_W           = 32,
   parameter int          ERR_HI_LSB      = 15,
   parameter int          ILEN_W          = 5,
   parameter int          ILEN_MIN        = 1,
   parameter int          ILEN_MAX        = 15,
   parameter int          NMI_VECTOR      = 2,
   parameter int          HWEXC_VEC_LIMIT = 31,
   parameter logic [31:0] ERRCODE_VECTORS = 32'h0002_7D00
)(
   input  info_fields_t      fields,
   input  logic [ERR_W-1:0]  errcode,
   input  logic [ILEN_W-1:0] ilen,
   output viol_t             raw
);

   localparam int LOOKUP_W = $clog2($bits(ERRCODE_VECTORS));

   logic is_nmi, is_hwexc, is_swlike, is_rsv;
   logic vec_in_set;
   logic err_hi_nz;
   logic ilen_bad;
   logic unused_err_lo;

   always_comb begin
      is_nmi    = (fields.kind == KIND_NMI);
      is_hwexc  = (fields.kind == KIND_HWEXC);
      is_rsv    = (fields.kind == KIND_RSV1) || (fields.kind == KIND_RSV7);
      is_swlike = (fields.kind == KIND_SWINT) || (fields.kind == KIND_PRIVSW) ||
                  (fields.kind == KIND_SWEXC);
   end

   // Vector-set lookup: wider vectors need their upper bits to be zero
   generate
      if (VEC_W > LOOKUP_W) begin : g_wide_vec
         assign vec_in_set = (fields.vec[VEC_W-1:LOOKUP_W] == '0) &&
                             ERRCODE_VECTORS[fields.vec[LOOKUP_W-1:0]];
      end else begin : g_narrow_vec
         assign vec_in_set = ERRCODE_VECTORS[fields.vec];
      end
   endgenerate

   assign err_hi_nz     = |errcode[ERR_W-1:ERR_HI_LSB];
   assign unused_err_lo = ^errcode[ERR_HI_LSB-1:0];

   // Length window; a zero lower bound needs no low compare
   generate
      if (ILEN_MIN == 0) begin : g_no_low_bound
         assign ilen_bad = (ilen > ILEN_W'(ILEN_MAX));
      end else begin : g_low_bound
         assign ilen_bad = (ilen < ILEN_W'(ILEN_MIN)) || (ilen > ILEN_W'(ILEN_MAX));
      end
   endgenerate

   always_comb begin
      raw                 = '0;
      raw[RULE_RSV_KIND]  = is_rsv;
      raw[RULE_NMI_VEC]   = is_nmi && (fields.vec != VEC_W'(NMI_VECTOR));
      raw[RULE_HWEXC_VEC] = is_hwexc && (fields.vec > VEC_W'(HWEXC_VEC_LIMIT));
      raw[RULE_ERRFLAG]   = fields.deliver != (is_hwexc && vec_in_set);
      raw[RULE_RSV_BITS]  = |fields.rsv;
      raw[RULE_ERR_HI]    = fields.deliver && err_hi_nz;
      raw[RULE_ILEN]      = is_swlike && ilen_bad;
   end

endmodule

// File: rtl/inj_evt_result.sv
module inj_evt_result
   import inj_evt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strobe,
   input  logic  armed,
   input  viol_t raw,
   output logic  done,
   output logic  fail,
   output viol_t viol
);

   viol_t gated;

   // One gate and one flop per rule
   generate
      for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
         assign gated[g] = armed & raw[g];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      viol[g] <= 1'b0;
            else if (strobe) viol[g] <= gated[g];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         fail <= 1'b0;
      end else begin
         done <= strobe;
         if (strobe) fail <= |gated;
      end
   end

   a_r10_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> done);
   a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> (!done && $stable(viol) && $stable(fail)));
   a_r1_disarmed_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !armed) |=> (viol == '0 && !fail));
   a_r9_fail_matches_any: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fail == (viol != '0)));

endmodule

// File: rtl/inj_evt_validator.sv
module inj_evt_validator
   import inj_evt_pkg::*;
#(
   parameter int          ERR_W           = 32,
   parameter int          ERR_HI_LSB      = 15,
   parameter int          ILEN_W          = 5,
   parameter int          ILEN_MIN        = 1,
   parameter int          ILEN_MAX        = 15,
   parameter int          NMI_VECTOR      = 2,
   parameter int          HWEXC_VEC_LIMIT = 31,
   parameter logic [31:0] ERRCODE_VECTORS = 32'h0002_7D00
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chk_valid,
   input  logic [INFO_W-1:0]    evt_info,
   input  logic [ERR_W-1:0]     evt_errcode,
   input  logic [ILEN_W-1:0]    evt_ilen,
   output logic                 chk_done,
   output logic                 chk_fail,
   output logic [NUM_RULES-1:0] chk_viol
);

   // Elaboration-time parameter checks
   generate
      if (ILEN_MAX >= (1 << ILEN_W)) begin : g_bad_ilen_max
         $error("ILEN_MAX does not fit in ILEN_W bits");
      end
      if (ILEN_MIN > ILEN_MAX) begin : g_bad_ilen_range
         $error("ILEN_MIN exceeds ILEN_MAX");
      end
      if (ERR_HI_LSB < 1 || ERR_HI_LSB >= ERR_W) begin : g_bad_err_split
         $error("ERR_HI_LSB must lie inside the error-code word");
      end
      if (NMI_VECTOR >= (1 << VEC_W) || HWEXC_VEC_LIMIT >= (1 << VEC_W)) begin : g_bad_vec
         $error("vector constants exceed the vector field");
      end
   endgenerate

   info_fields_t fields;
   viol_t        raw;
   viol_t        viol_q;

   inj_evt_fields u_fields (
      .info   (evt_info),
      .fields (fields)
   );

   inj_evt_rules #(
      .ERR_W           (ERR_W),
      .ERR_HI_LSB      (ERR_HI_LSB),
      .ILEN_W          (ILEN_W),
      .ILEN_MIN        (ILEN_MIN),
      .ILEN_MAX        (ILEN_MAX),
      .NMI_VECTOR      (NMI_VECTOR),
      .HWEXC_VEC_LIMIT (HWEXC_VEC_LIMIT),
      .ERRCODE_VECTORS (ERRCODE_VECTORS)
   ) u_rules (
      .fields  (fields),
      .errcode (evt_errcode),
      .ilen    (evt_ilen),
      .raw     (raw)
   );

   inj_evt_result u_result (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (chk_valid),
      .armed  (fields.armed),
      .raw    (raw),
      .done   (chk_done),
      .fail   (chk_fail),
      .viol   (viol_q)
   );

   assign chk_viol = viol_q;

   // Port-level rule checks
   a_r2_reserved_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && evt_info[ARMED_BIT] &&
       (evt_info[KIND_MSB:KIND_LSB] == 3'd1 || evt_info[KIND_MSB:KIND_LSB] == 3'd7))
      |=> (chk_viol[RULE_RSV_KIND] && chk_fail));
   a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && evt_info[ARMED_BIT] && evt_info[KIND_MSB:KIND_LSB] == 3'd2 &&
       evt_info[VEC_MSB:0] != VEC_W'(NMI_VECTOR))
      |=> chk_viol[RULE_NMI_VEC]);
   a_r6_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && evt_info[ARMED_BIT] && evt_info[RSV_MSB:RSV_LSB] != '0)
      |=> chk_viol[RULE_RSV_BITS]);
   a_r7_errcode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !evt_info[DELIV_BIT]) |=> !chk_viol[RULE_ERR_HI]);
   a_r8_ilen_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && evt_info[KIND_MSB:KIND_LSB] < 3'd4) |=> !chk_viol[RULE_ILEN]);

endmodule

// File: tb/test_inj_evt_validator.sv
module test_inj_evt_validator;

   localparam int N_ROWS = 27;
   // Row: {req[3:0], info[31:0], errcode[31:0], ilen[4:0], expected viol[6:0]}
   localparam logic [79:0] TBL [0:N_ROWS-1] = '{
      {4'd1,  32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0,  7'b0000000}, // R1 disarmed, junk
      {4'd2,  32'h8000_0020, 32'h0000_0000, 5'd0,  7'b0000000}, // R2 ext int ok
      {4'd2,  32'h8000_0100, 32'h0000_0000, 5'd0,  7'b0000001}, // R2 kind 1
      {4'd2,  32'h8000_0700, 32'h0000_0000, 5'd0,  7'b0000001}, // R2 kind 7
      {4'd3,  32'h8000_0202, 32'h0000_0000, 5'd0,  7'b0000000}, // R3 NMI vec 2
      {4'd3,  32'h8000_0203, 32'h0000_0000, 5'd0,  7'b0000010}, // R3 NMI vec 3
      {4'd4,  32'h8000_031F, 32'h0000_0000, 5'd0,  7'b0000000}, // R4 vec 31
      {4'd4,  32'h8000_0320, 32'h0000_0000, 5'd0,  7'b0000100}, // R4 vec 32
      {4'd5,  32'h8000_0B0D, 32'h0000_7FFF, 5'd0,  7'b0000000}, // R5 vec 13 flag set
      {4'd5,  32'h8000_030D, 32'h0000_0000, 5'd0,  7'b0001000}, // R5 vec 13 flag clear
      {4'd5,  32'h8000_0B06, 32'h0000_0000, 5'd0,  7'b0001000}, // R5 vec 6 flag set
      {4'd5,  32'h8000_0808, 32'h0000_0000, 5'd0,  7'b0001000}, // R5 ext int flag set
      {4'd5,  32'h8000_0B11, 32'h0000_0000, 5'd0,  7'b0000000}, // R5 vec 17
      {4'd5,  32'h8000_030A, 32'h0000_0000, 5'd0,  7'b0001000}, // R5 vec 10 flag clear
      {4'd5,  32'h8000_0A02, 32'h0000_0000, 5'd0,  7'b0001000}, // R5 NMI flag set
      {4'd7,  32'h8000_0B0E, 32'h0000_8000, 5'd0,  7'b0100000}, // R7 err bit 15
      {4'd7,  32'h8000_0308, 32'hFFFF_FFFF, 5'd0,  7'b0001000}, // R7 flag clear ignores err
      {4'd6,  32'h8000_1000, 32'h0000_0000, 5'd0,  7'b0010000}, // R6 bit 12
      {4'd6,  32'hC000_0000, 32'h0000_0000, 5'd0,  7'b0010000}, // R6 bit 30
      {4'd8,  32'h8000_0480, 32'h0000_0000, 5'd0,  7'b1000000}, // R8 len 0
      {4'd8,  32'h8000_0480, 32'h0000_0000, 5'd15, 7'b0000000}, // R8 len 15
      {4'd8,  32'h8000_0480, 32'h0000_0000, 5'd16, 7'b1000000}, // R8 len 16
      {4'd8,  32'h8000_0501, 32'h0000_0000, 5'd1,  7'b0000000}, // R8 len 1
      {4'd8,  32'h8000_0603, 32'h0000_0000, 5'd31, 7'b1000000}, // R8 len 31
      {4'd8,  32'h8000_0303, 32'h0000_0000, 5'd0,  7'b0000000}, // R8 hw exc ignores len
      {4'd9,  32'h8010_0A05, 32'hFFFF_0000, 5'd0,  7'b0111010}, // R9 several at once
      {4'd1,  32'h0000_0B20, 32'hFFFF_FFFF, 5'd0,  7'b0000000}  // R1 disarmed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_valid = 1'b0;
   logic [31:0] evt_info = '0;
   logic [31:0] evt_errcode = '0;
   logic [4:0]  evt_ilen = '0;
   logic        chk_done;
   logic        chk_fail;
   logic [6:0]  chk_viol;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   inj_evt_validator i_inj_evt_validator (
      .clk         (clk),
      .rst_n       (rst_n),
      .chk_valid   (chk_valid),
      .evt_info    (evt_info),
      .evt_errcode (evt_errcode),
      .evt_ilen    (evt_ilen),
      .chk_done    (chk_done),
      .chk_fail    (chk_fail),
      .chk_viol    (chk_viol)
   );

   task automatic check(input string tag, input logic exp_done, input logic [6:0] exp_viol);
      n_tests++;
      if (chk_done !== exp_done || chk_viol !== exp_viol || chk_fail !== (|exp_viol)) begin
         n_fail++;
         $display("FAIL %s: done=%b viol=%b fail=%b, expected done=%b viol=%b fail=%b",
                  tag, chk_done, chk_viol, chk_fail, exp_done, exp_viol, |exp_viol);
      end
   endtask

   task automatic drive(input logic [31:0] info, input logic [31:0] err, input logic [4:0] len);
      evt_info    = info;
      evt_errcode = err;
      evt_ilen    = len;
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset state", 1'b0, 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", 1'b0, 7'b0);

      // Table walk: strobe on a falling edge, read one cycle later
      for (int i = 0; i < N_ROWS; i++) begin
         drive(TBL[i][75:44], TBL[i][43:12], TBL[i][11:7]);
         chk_valid = 1'b1;
         @(negedge clk);
         chk_valid = 1'b0;
         check($sformatf("R%0d row %0d", TBL[i][79:76], i), 1'b1, TBL[i][6:0]);
      end

      // R10: done drops and result holds while inputs change without strobe
      drive(32'h8000_0100, 32'h0, 5'd0);
      chk_valid = 1'b1;
      @(negedge clk);
      chk_valid = 1'b0;
      check("R2 kind 1 before hold", 1'b1, 7'b0000001);
      drive(32'h8010_0A05, 32'hFFFF_0000, 5'd0);
      @(negedge clk);
      check("R10 hold cycle 1", 1'b0, 7'b0000001);
      drive(32'h8000_0480, 32'h0, 5'd0);
      @(negedge clk);
      check("R10 hold cycle 2", 1'b0, 7'b0000001);

      // R10: back-to-back strobes, each result in its own cycle
      drive(32'h8000_0203, 32'h0, 5'd0);
      chk_valid = 1'b1;
      @(negedge clk);
      check("R3 first of pair", 1'b1, 7'b0000010);
      drive(32'h8000_0B0D, 32'h0, 5'd0);
      @(negedge clk);
      chk_valid = 1'b0;
      check("R5 second of pair", 1'b1, 7'b0000000);
      @(negedge clk);
      check("R10 done drops after pair", 1'b0, 7'b0000000);

      // R8: privileged software exception just past the upper length bound
      drive(32'h8000_0501, 32'h0, 5'd16);
      chk_valid = 1'b1;
      @(negedge clk);
      chk_valid = 1'b0;
      check("R8 kind 5 len 16", 1'b1, 7'b1000000);

      // R1: disarmed word that would break every rule
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      chk_valid = 1'b1;
      @(negedge clk);
      chk_valid = 1'b0;
      check("R1 disarmed clears previous fail", 1'b1, 7'b0000000);

      // R10: reset while a failing result is held
      drive(32'h8000_0700, 32'h0, 5'd0);
      chk_valid = 1'b1;
      @(negedge clk);
      chk_valid = 1'b0;
      check("R2 before mid-run reset", 1'b1, 7'b0000001);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 mid-run reset clears", 1'b0, 7'b0000000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after mid-run reset", 1'b0, 7'b0000000);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule